// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation row vectors by a square weight matrix that stays inside the array. A grid of N by N multiply-accumulate cells keeps one signed 8-bit weight per cell. Activations enter at the left edge of each grid row and step one cell to the right on every clock. Each cell passes its activation on unchanged, so a value that enters the array once is used by every cell in that row. Partial sums start at zero at the top of each column. In every cell they pick up weight times activation and move down one cell per clock. For each accepted activation vector x, the bottom of column j yields y[j], the sum over i of x[i] times W[i][j].

Skew delay lines on the input hold activation element i back by i clocks, so the matching operands reach each cell in the same cycle. Deskew delay lines on the output hold column j back by N-1-j clocks, so all N results of one row appear together under a single out_valid strobe. A valid tag moves through a pipeline alongside the data.

A small controller sequences the block through four states. IDLE waits for work. LOAD shifts weight rows down the columns. COMPUTE accepts activation rows. DRAIN empties the pipeline.

The transitions are these. IDLE goes to LOAD when load_en is high, and to COMPUTE when in_valid is high without load_en. LOAD stays in LOAD while load_en is high. When load_en drops, LOAD goes to COMPUTE if in_valid is high, and otherwise to IDLE. COMPUTE goes to DRAIN when in_valid drops. DRAIN returns to COMPUTE when in_valid rises again. DRAIN goes to IDLE once the last row in flight reaches the output.

Top module: `ws_systolic_mm`

## Requirements
- R1: After reset, out_valid and busy are both 0.
- R2: A clock with load_en high while the block is not busy shifts every column's weights down one cell and puts load_w into grid row 0, with element j taken from bits [8j+7:8j]. After N such clocks, the vector applied on load clock k (counting from 0) sits in grid row N-1-k. Grid row i therefore multiplies activation element i.
- R3: For each accepted activation row, y_out carries y[j] = sum over i of x[i]*W[i][j]. Column j sits in bits [AW*j+AW-1:AW*j] as a signed AW-bit value. Activation element i is taken from act_in bits [8i+7:8i]. Both operands are signed two's complement 8-bit values.
- R4: A row accepted at clock edge t produces exactly one out_valid cycle, starting after edge t+2N-2. Results leave in acceptance order. M back-to-back rows therefore finish within M+2N-2 clocks.
- R5: All N elements of one result row are presented in the same cycle, under one out_valid pulse.
- R6: Gaps in in_valid while computing are reproduced as identical gaps in out_valid, and results stay correct.
- R7: load_en is ignored while busy is high. The weights used afterwards are unchanged.
- R8: busy rises on the clock after the first accepted row. It stays high until the edge after the last out_valid cycle, at which edge it drops to 0.
- R9: While the block is not busy and load_en is high, in_valid is not accepted. No result row is produced for it.
- R10: Extreme operands do not overflow. With N=4 and AW=18, all -128 weights times all -128 activations give 65536. All 127 weights times all -128 activations give -65024.
- R11: Loaded weights persist across any number of compute batches until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Shift a weight row into the array this clock |
| load_w | input | N*DW | Weight row entering grid row 0, element j at bits [8j+7:8j] |
| in_valid | input | 1 | act_in holds an activation row |
| act_in | input | N*DW | Activation row, element i at bits [8i+7:8i] |
| out_valid | output | 1 | y_out holds a complete result row |
| y_out | output | N*AW | Result row, column j at bits [AW*j+AW-1:AW*j] |
| busy | output | 1 | Rows are in flight; load_en is ignored |

## Verification
The hardest situation to reach is a load request that arrives while rows are still in the pipeline, together with a load request that overlaps in_valid while the block is idle. Neither one shows up directly at the outputs. The bench drives load_en with different weights during a streaming batch and then runs a second batch. Wrong weights would appear as wrong sums, and an accepted load would appear as unexpected result rows. The same check applies to the overlap while idle: the bench raises in_valid together with every load clock and then watches for result rows it never expected. Gap patterns in in_valid check the drain and re-entry transitions, with a cycle stamp on every result.

// File: rtl/ws_mm_pkg.sv
package ws_mm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_COMPUTE = 2'd2,
        ST_DRAIN   = 2'd3
    } mm_state_e;
endpackage

// File: rtl/ws_mm_delay.sv
// Fixed-depth register delay line; depth 0 is a plain wire.
module ws_mm_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] stage_q [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
                end
            end
            assign dout = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ws_mm_cell.sv
// One processing element: a held weight, a forwarded activation and a partial sum.
module ws_mm_cell #(
    parameter int DW = 8,
    parameter int AW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_shift,
    input  logic [DW-1:0]        w_in,
    output logic [DW-1:0]        w_out,
    input  logic [DW-1:0]        a_in,
    output logic [DW-1:0]        a_out,
    input  logic signed [AW-1:0] p_in,
    output logic signed [AW-1:0] p_out
);
    localparam int PW = 2 * DW;

    logic [DW-1:0]        w_q;
    logic [DW-1:0]        a_q;
    logic signed [AW-1:0] p_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    assign prod     = $signed(w_q) * $signed(a_in);
    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
            a_q <= '0;
            p_q <= '0;
        end else begin
            if (w_shift) w_q <= w_in;
            a_q <= a_in;
            p_q <= p_in + prod_ext;
        end
    end

    assign w_out = w_q;
    assign a_out = a_q;
    assign p_out = p_q;
endmodule

// File: rtl/ws_mm_ctrl.sv
// Phase sequencer plus the valid tag pipeline that follows the data.
module ws_mm_ctrl
    import ws_mm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic in_valid,
    output logic w_shift,
    output logic accept,
    output logic out_valid,
    output logic busy
);
    localparam int VL = 2 * N - 1;

    mm_state_e      state_q, state_d;
    logic [VL-1:0]  vpipe_q;
    logic           pipe_tail_empty;

    assign pipe_tail_empty = (vpipe_q[VL-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_en)       state_d = ST_LOAD;
                else if (in_valid) state_d = ST_COMPUTE;
            end
            ST_LOAD: begin
                if (load_en)       state_d = ST_LOAD;
                else if (in_valid) state_d = ST_COMPUTE;
                else               state_d = ST_IDLE;
            end
            ST_COMPUTE: begin
                if (!in_valid)     state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (in_valid)             state_d = ST_COMPUTE;
                else if (pipe_tail_empty) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        w_shift = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD:     w_shift = load_en;
            ST_COMPUTE, ST_DRAIN: busy    = 1'b1;
            default: ;
        endcase
        accept = in_valid && !w_shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpipe_q <= '0;
        else        vpipe_q <= {vpipe_q[VL-2:0], accept};
    end

    assign out_valid = vpipe_q[VL-1];
endmodule

// File: rtl/ws_systolic_mm.sv
module ws_systolic_mm #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 2 * DW + $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [N*DW-1:0] load_w,
    input  logic          in_valid,
    input  logic [N*DW-1:0] act_in,
    output logic          out_valid,
    output logic [N*AW-1:0] y_out,
    output logic          busy
);
    logic w_shift;
    logic accept;

    logic [DW-1:0]        a_h [N][N+1];
    logic signed [AW-1:0] p_v [N+1][N];
    logic [DW-1:0]        w_v [N+1][N];
    logic [N*N*DW-1:0]    w_flat;

    ws_mm_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .in_valid  (in_valid),
        .w_shift   (w_shift),
        .accept    (accept),
        .out_valid (out_valid),
        .busy      (busy)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_skew
            logic [DW-1:0] gated;
            assign gated = accept ? act_in[i*DW +: DW] : '0;
            ws_mm_delay #(.WIDTH(DW), .DEPTH(i)) u_skew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (gated),
                .dout (a_h[i][0])
            );
        end

        for (genvar j = 0; j < N; j++) begin : g_top
            assign p_v[0][j] = '0;
            assign w_v[0][j] = load_w[j*DW +: DW];
        end

        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                ws_mm_cell #(.DW(DW), .AW(AW)) u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .w_shift(w_shift),
                    .w_in   (w_v[i][j]),
                    .w_out  (w_v[i+1][j]),
                    .a_in   (a_h[i][j]),
                    .a_out  (a_h[i][j+1]),
                    .p_in   (p_v[i][j]),
                    .p_out  (p_v[i+1][j])
                );
                assign w_flat[(i*N+j)*DW +: DW] = w_v[i+1][j];
            end
        end

        for (genvar j = 0; j < N; j++) begin : g_deskew
            ws_mm_delay #(.WIDTH(AW), .DEPTH(N-1-j)) u_deskew (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (p_v[N][j]),
                .dout (y_out[j*AW +: AW])
            );
        end
    endgenerate
endmodule

// File: rtl/ws_systolic_mm_chk.sv
module ws_systolic_mm_chk #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_en,
    input logic              accept,
    input logic              busy,
    input logic              out_valid,
    input logic [N*N*DW-1:0] w_flat
);
    int unsigned rows_in, rows_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_in  <= 0;
            rows_out <= 0;
        end else begin
            if (accept)    rows_in  <= rows_in + 1;
            if (out_valid) rows_out <= rows_out + 1;
        end
    end

    assert_busy_covers_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_drain_ends_on_last_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid));

    assert_rows_not_invented_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rows_out <= rows_in);

    assert_idle_all_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rows_out == rows_in));

    assert_weights_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_en) |=> $stable(w_flat));

    assert_weights_hold_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(w_flat));
endmodule

bind ws_systolic_mm ws_systolic_mm_chk #(.N(N), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .accept   (accept),
    .busy     (busy),
    .out_valid(out_valid),
    .w_flat   (w_flat)
);

// File: tb/ws_systolic_mm_tb.sv
`timescale 1ns/1ps
module ws_systolic_mm_tb;
    localparam int N   = 4;
    localparam int DW  = 8;
    localparam int AW  = 2 * DW + $clog2(N);
    localparam int LAT = 2 * N - 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [N*DW-1:0] load_w = '0;
    logic            in_valid = 1'b0;
    logic [N*DW-1:0] act_in = '0;
    logic            out_valid;
    logic [N*AW-1:0] y_out;
    logic            busy;

    ws_systolic_mm #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_w(load_w),
        .in_valid(in_valid), .act_in(act_in), .out_valid(out_valid),
        .y_out(y_out), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int n_chk = 0, n_fail = 0;
    int wm [N][N];
    int wv [N][N];
    int xr [N];
    int exp_y [256][N];
    int exp_c [256];
    int wr = 0, rd = 0;
    bit done = 0;

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Output monitor: value and cycle of every result row (R3 R4 R5 R6)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected result row: actual out_valid 1 expected 0");
            end else begin
                int badc;
                int got;
                badc = -1;
                got = 0;
                for (int j = 0; j < N; j++) begin
                    if (badc < 0 && int'($signed(y_out[j*AW +: AW])) != exp_y[rd][j]) begin
                        badc = j;
                        got = int'($signed(y_out[j*AW +: AW]));
                    end
                end
                n_chk++;
                if (badc >= 0) begin
                    n_fail++;
                    $display("FAIL R3 row %0d col %0d: actual %0d expected %0d", rd, badc, got, exp_y[rd][badc]);
                end else if (cyc != exp_c[rd]) begin
                    n_fail++;
                    $display("FAIL R4 row %0d timing: actual cycle %0d expected %0d", rd, cyc, exp_c[rd]);
                end
                rd++;
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic gen_w(int seed);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                wv[i][j] = ((seed * 13 + i * 37 + j * 59 + i * j * 7) % 256) - 128;
    endtask

    task automatic const_w(int c);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) wv[i][j] = c;
    endtask

    task automatic gen_x(int s);
        for (int i = 0; i < N; i++) xr[i] = ((s * 29 + i * 71 + 5 + s * i * 3) % 256) - 128;
    endtask

    // R2: vector applied on load clock k lands in grid row N-1-k
    task automatic load_wv(bit with_valid);
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < N; j++) load_w[j*DW +: DW] = DW'(wv[N-1-k][j]);
            load_en = 1'b1;
            in_valid = with_valid;
            step();
        end
        load_en = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) wm[i][j] = wv[i][j];
    endtask

    task automatic send(bit v);
        if (v) begin
            for (int i = 0; i < N; i++) act_in[i*DW +: DW] = DW'(xr[i]);
            for (int j = 0; j < N; j++) begin
                int s;
                s = 0;
                for (int i = 0; i < N; i++) s += xr[i] * wm[i][j];
                exp_y[wr][j] = s;
            end
            exp_c[wr] = cyc + 1 + LAT;
            wr++;
        end
        in_valid = v;
        step();
        in_valid = 1'b0;
    endtask

    task automatic wait_idle(output int at);
        for (int k = 0; k < 200 && busy; k++) step();
        at = cyc;
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
    endtask

    task automatic t_stream();
        int t_last, at;
        gen_w(1);
        load_wv(0);
        for (int r = 0; r < 5; r++) begin
            gen_x(r + 1);
            send(1);
            if (r == 0) check(busy == 1'b1, "R8 busy after first row", busy, 1);
        end
        t_last = cyc;
        wait_idle(at);
        check(at == t_last + 2 * N - 1, "R8 busy drop cycle", at, t_last + 2 * N - 1);
        check(rd == wr, "R4 all rows delivered", rd, wr);
    endtask

    task automatic t_gaps();
        int at;
        bit pat [9] = '{1, 0, 1, 1, 0, 0, 1, 0, 1};
        for (int k = 0; k < 9; k++) begin
            gen_x(40 + k);
            send(pat[k]);
        end
        wait_idle(at);
        check(rd == wr, "R6 gapped rows delivered", rd, wr);
    endtask

    task automatic t_load_while_busy();
        int at;
        gen_x(60);
        send(1);
        load_en = 1'b1;
        for (int j = 0; j < N; j++) load_w[j*DW +: DW] = 8'h11;
        for (int r = 0; r < 4; r++) begin
            gen_x(61 + r);
            send(1);
        end
        load_en = 1'b0;
        wait_idle(at);
        // R7 R11: a later batch must still use the old weights
        for (int r = 0; r < 3; r++) begin
            gen_x(80 + r);
            send(1);
        end
        wait_idle(at);
        check(rd == wr, "R7 rows after ignored load", rd, wr);
    endtask

    task automatic t_load_with_valid();
        int at;
        gen_x(90);
        for (int i = 0; i < N; i++) act_in[i*DW +: DW] = DW'(xr[i]);
        gen_w(7);
        load_wv(1);
        check(busy == 1'b0, "R9 busy after load with in_valid", busy, 0);
        for (int k = 0; k < 2 * N; k++) step();
        check(busy == 1'b0, "R9 still idle", busy, 0);
        for (int r = 0; r < 3; r++) begin
            gen_x(100 + r);
            send(1);
        end
        wait_idle(at);
        check(rd == wr, "R2 rows with new weights", rd, wr);
    endtask

    task automatic t_extremes();
        int at;
        const_w(-128);
        load_wv(0);
        for (int i = 0; i < N; i++) xr[i] = -128;
        send(1);
        wait_idle(at);
        const_w(127);
        load_wv(0);
        for (int i = 0; i < N; i++) xr[i] = -128;
        send(1);
        for (int i = 0; i < N; i++) xr[i] = 127;
        send(1);
        wait_idle(at);
        check(exp_y[wr-3][0] == 65536, "R10 model max", exp_y[wr-3][0], 65536);
        check(rd == wr, "R10 extreme rows delivered", rd, wr);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_stream();
        t_gaps();
        t_load_while_busy();
        t_load_with_valid();
        t_extremes();
        repeat (4) step();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule